// File: doc/BRIEF.md
# Address Security Attribution Unit

This block assigns every bus address a final security attribute: secure, non-secure or non-secure-callable. Two sources are combined. A hard-wired address map splits the 4-Gbyte space into coarse windows. Code memory, SRAM and peripheral space each appear twice, once as a non-secure alias and once as a non-secure-callable alias. External memory space is not aliased and is non-secure. Eight programmable regions, written through a simple register-write port, then mark address ranges as non-secure or non-secure-callable. Any address that no region covers is secure in the programmable result.

The lookup is purely combinational from the access address to the attribute. Only the region registers hold state. The final attribute is the stricter of the fixed-map result and the programmable result. A global enable turns attribution off, and every address then reports non-secure. Alongside the attribute, the block reports whether exactly one programmable region matched and which one it was. Raising faults and comparing the requester's state against the attribute are left to neighbouring logic.

Top module: `asau_top`

## Requirements
- R1: `attr` is encoded 2'b00 non-secure, 2'b01 non-secure-callable, 2'b10 secure, strictness rising in that order. While `secEnable` is low, `attr` is 2'b00, `regionHit` is 0 and `regionNum` is 0 for any address.
- R2: The fixed map gives non-secure for addresses whose top nibble is 0x1, 0x2, 0x4 or 0x6 through 0xD, and for 0x0000_0000–0x0BFF_FFFF. It gives non-secure-callable for 0x0C00_0000–0x0FFF_FFFF and for top nibbles 0x3 and 0x5. It gives secure for top nibbles 0xE and 0xF.
- R3: A region matches when its enable bit is set and addr[31:5] lies between its base and limit fields, both ends inclusive. This gives 32-byte granularity, so a limit value L covers up to byte address L*32+31.
- R4: With no region matching, the programmable result is secure and `regionHit`=0, `regionNum`=0.
- R5: With exactly one region matching, `regionHit`=1, `regionNum` is that region's index, and the programmable result is non-secure-callable if the region's callable flag is set and non-secure otherwise.
- R6: With two or more regions matching, the programmable result is secure and `regionHit`=0, `regionNum`=0.
- R7: With `secEnable` high, `attr` is the stricter of the fixed-map and programmable results.
- R8: A cycle with `regWrEn` high loads base, limit, enable and callable flag of region `regWrIdx` at that clock edge. The lookup uses the new values from then on, and the other regions are unchanged.
- R9: After reset, every region is disabled, so every address gets a secure programmable result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| secEnable | input | 1 | Global attribution enable |
| regWrEn | input | 1 | Region register write strobe |
| regWrIdx | input | 3 | Index of the region being written |
| regWrBase | input | 27 | Region base, address bits 31:5 |
| regWrLimit | input | 27 | Region inclusive limit, address bits 31:5 |
| regWrActive | input | 1 | Region enable bit to load |
| regWrCallable | input | 1 | Region callable flag to load |
| accAddr | input | 32 | Access address to attribute |
| attr | output | 2 | Final security attribute |
| regionHit | output | 1 | Exactly one programmable region matched |
| regionNum | output | 3 | Index of the matching region |

## Verification
The assertions take `secEnable`, `accAddr` and the write port to be settled, known values at each clock edge. They also assume `regWrIdx` never exceeds the region count, because the write decode checks that exactly one region loads per write. The stimulus changes inputs only on the falling edge. It draws write indices from 0 to 7, and it always loads a limit no lower than the base so that region spans are meaningful. Random addresses are aimed at the neighbourhood of programmed regions so that single hits, overlaps and edge misses all occur.

// File: rtl/asau_pkg.sv
package asau_pkg;
  parameter int unsigned NUM_REGIONS = 8;
  parameter int unsigned ADDR_W      = 32;
  parameter int unsigned GRAN_BITS   = 5;
  localparam int unsigned IDX_W   = $clog2(NUM_REGIONS);
  localparam int unsigned FIELD_W = ADDR_W - GRAN_BITS;

  typedef enum logic [1:0] {
    ATTR_NS  = 2'b00,
    ATTR_NSC = 2'b01,
    ATTR_SEC = 2'b10
  } attr_e;

  typedef struct packed {
    logic [FIELD_W-1:0] base;
    logic [FIELD_W-1:0] limit;
    logic               active;
    logic               callable;
  } region_t;

  typedef struct packed {
    logic [NUM_REGIONS-1:0] load;
    logic                   lookupOn;
  } asauStrobe_t;

  function automatic attr_e stricter(attr_e a, attr_e b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/asau_ctrl.sv
module asau_ctrl
  import asau_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             secEnable,
  input  logic             regWrEn,
  input  logic [IDX_W-1:0] regWrIdx,
  output asauStrobe_t      strobes
);
  always_comb begin
    for (int i = 0; i < NUM_REGIONS; i++) begin
      strobes.load[i] = regWrEn && (regWrIdx == IDX_W'(i));
    end
    strobes.lookupOn = secEnable;
  end

  AST_ONE_LOAD_PER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> ($countones(strobes.load) == 1)); // R8
  AST_NO_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> (strobes.load == '0)); // R8
endmodule

// File: rtl/asau_datapath.sv
module asau_datapath
  import asau_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  asauStrobe_t        strobes,
  input  logic [FIELD_W-1:0] wrBase,
  input  logic [FIELD_W-1:0] wrLimit,
  input  logic               wrActive,
  input  logic               wrCallable,
  input  logic [ADDR_W-1:0]  accAddr,
  output attr_e              attr,
  output logic               regionHit,
  output logic [IDX_W-1:0]   regionNum
);
  region_t                regions [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] matchVec;
  logic [FIELD_W-1:0]     addrField;
  logic [IDX_W-1:0]       firstIdx;
  logic                   singleHit;
  logic                   multiHit;
  attr_e                  fixedAttr;
  attr_e                  progAttr;

  assign addrField = accAddr[ADDR_W-1:GRAN_BITS];

  generate
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegion
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          regions[g] <= '0;
        end else if (strobes.load[g]) begin
          regions[g] <= '{base: wrBase, limit: wrLimit,
                          active: wrActive, callable: wrCallable};
        end
      end

      assign matchVec[g] = regions[g].active &&
                           (addrField >= regions[g].base) &&
                           (addrField <= regions[g].limit);

      AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rstN)
        strobes.load[g] |=> (regions[g].base == $past(wrBase)) &&
                            (regions[g].limit == $past(wrLimit))); // R8
    end
  endgenerate

  always_comb begin
    firstIdx = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (matchVec[i]) firstIdx = IDX_W'(i);
    end
    singleHit = ($countones(matchVec) == 1);
    multiHit  = ($countones(matchVec) > 1);
  end

  // Hard-wired map: decided by the top address nibble, plus bits 27:26 in the first window.
  always_comb begin
    unique case (accAddr[ADDR_W-1 -: 4])
      4'h0:       fixedAttr = (accAddr[ADDR_W-5 -: 2] == 2'b11) ? ATTR_NSC : ATTR_NS;
      4'h3, 4'h5: fixedAttr = ATTR_NSC;
      4'hE, 4'hF: fixedAttr = ATTR_SEC;
      default:    fixedAttr = ATTR_NS;
    endcase
  end

  always_comb begin
    if (singleHit) begin
      progAttr = regions[firstIdx].callable ? ATTR_NSC : ATTR_NS;
    end else begin
      progAttr = ATTR_SEC;
    end
  end

  always_comb begin
    if (strobes.lookupOn) begin
      attr      = stricter(fixedAttr, progAttr);
      regionHit = singleHit;
      regionNum = singleHit ? firstIdx : '0;
    end else begin
      attr      = ATTR_NS;
      regionHit = 1'b0;
      regionNum = '0;
    end
  end

  AST_OFF_IS_NS: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.lookupOn |-> (attr == ATTR_NS) && !regionHit && (regionNum == '0)); // R1
  AST_NOT_WEAKER_THAN_MAP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lookupOn |-> (attr >= fixedAttr)); // R7
  AST_OVERLAP_SECURE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.lookupOn && multiHit) |-> (attr == ATTR_SEC) && !regionHit); // R6
  AST_HIT_IS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    regionHit |-> matchVec[regionNum] && $onehot(matchVec)); // R5
  AST_ENCODING_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    attr != 2'b11); // R1
endmodule

// File: rtl/asau_top.sv
module asau_top
  import asau_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               secEnable,
  input  logic               regWrEn,
  input  logic [IDX_W-1:0]   regWrIdx,
  input  logic [FIELD_W-1:0] regWrBase,
  input  logic [FIELD_W-1:0] regWrLimit,
  input  logic               regWrActive,
  input  logic               regWrCallable,
  input  logic [ADDR_W-1:0]  accAddr,
  output logic [1:0]         attr,
  output logic               regionHit,
  output logic [IDX_W-1:0]   regionNum
);
  asauStrobe_t strobes;
  attr_e       attrE;

  asau_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .secEnable (secEnable),
    .regWrEn   (regWrEn),
    .regWrIdx  (regWrIdx),
    .strobes   (strobes)
  );

  asau_datapath uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrBase     (regWrBase),
    .wrLimit    (regWrLimit),
    .wrActive   (regWrActive),
    .wrCallable (regWrCallable),
    .accAddr    (accAddr),
    .attr       (attrE),
    .regionHit  (regionHit),
    .regionNum  (regionNum)
  );

  assign attr = attrE;
endmodule

// File: tb/asau_top_test.sv
module asau_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secEnable = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrIdx = '0;
  logic [26:0] regWrBase = '0;
  logic [26:0] regWrLimit = '0;
  logic        regWrActive = 1'b0;
  logic        regWrCallable = 1'b0;
  logic [31:0] accAddr = '0;
  logic [1:0]  attr;
  logic        regionHit;
  logic [2:0]  regionNum;

  int checks = 0;
  int errors = 0;

  logic [26:0] mBase [NREG];
  logic [26:0] mLimit [NREG];
  logic        mOn [NREG];
  logic        mCall [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  asau_top uut (
    .clk(clk), .rstN(rstN), .secEnable(secEnable),
    .regWrEn(regWrEn), .regWrIdx(regWrIdx), .regWrBase(regWrBase),
    .regWrLimit(regWrLimit), .regWrActive(regWrActive),
    .regWrCallable(regWrCallable), .accAddr(accAddr),
    .attr(attr), .regionHit(regionHit), .regionNum(regionNum)
  );

  // Map reference written as explicit address ranges.
  function automatic logic [1:0] refMap(logic [31:0] a);
    if (a >= 32'hE000_0000) return 2'b10;
    if (a >= 32'h6000_0000) return 2'b00;
    if (a >= 32'h5000_0000) return 2'b01;
    if (a >= 32'h4000_0000) return 2'b00;
    if (a >= 32'h3000_0000) return 2'b01;
    if (a >= 32'h1000_0000) return 2'b00;
    if (a >= 32'h0C00_0000) return 2'b01;
    return 2'b00;
  endfunction

  // Expected {attr, hit, num}.
  function automatic logic [5:0] refAll(logic [31:0] a, logic en);
    int cnt = 0;
    int who = 0;
    logic [1:0] p;
    logic [1:0] f;
    if (!en) return 6'b0;
    for (int i = 0; i < NREG; i++) begin
      if (mOn[i] && ({5'b0, mBase[i]} * 32 <= a) && (a <= {5'b0, mLimit[i]} * 32 + 31)) begin
        cnt++;
        who = i;
      end
    end
    f = refMap(a);
    if (cnt == 1) p = mCall[who] ? 2'b01 : 2'b00;
    else p = 2'b10;
    return {(f > p) ? f : p, cnt == 1, (cnt == 1) ? 3'(who) : 3'd0};
  endfunction

  function automatic string tagFor(logic [31:0] a, logic en);
    int cnt = 0;
    if (!en) return "R1";
    for (int i = 0; i < NREG; i++)
      if (mOn[i] && ({5'b0, mBase[i]} * 32 <= a) && (a <= {5'b0, mLimit[i]} * 32 + 31)) cnt++;
    if (cnt == 0) return "R4/R7";
    if (cnt == 1) return "R5/R7";
    return "R6";
  endfunction

  task automatic check(string tag, logic [5:0] got, logic [5:0] exp, logic [31:0] a);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual attr/hit/num=%b expected=%b", tag, a, got, exp);
    end
  endtask

  task automatic probe(logic [31:0] a, string tag);
    @(negedge clk);
    accAddr = a;
    #1;
    check(tag, {attr, regionHit, regionNum}, refAll(a, secEnable), a);
  endtask

  task automatic probeAuto(logic [31:0] a);
    probe(a, tagFor(a, secEnable));
  endtask

  task automatic writeRegion(int idx, logic [26:0] b, logic [26:0] l, logic on, logic call);
    @(negedge clk);
    regWrEn = 1'b1; regWrIdx = 3'(idx); regWrBase = b; regWrLimit = l;
    regWrActive = on; regWrCallable = call;
    @(negedge clk);
    regWrEn = 1'b0;
    mBase[idx] = b; mLimit[idx] = l; mOn[idx] = on; mCall[idx] = call;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h0A5A_11CE));
    for (int i = 0; i < NREG; i++) begin
      mBase[i] = '0; mLimit[i] = '0; mOn[i] = 1'b0; mCall[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R1: disabled, even for secure-mapped address
    probe(32'hF000_0000, "R1");
    probe(32'h3000_0040, "R1");
    secEnable = 1'b1;
    // R9: after reset nothing matches, programmable result is secure
    probe(32'h2000_0000, "R9");
    probe(32'h4000_1000, "R9");

    // R8: program region 2 as non-secure over 0x2000_0100..0x2000_01FF
    writeRegion(2, 27'h100_0008, 27'h100_000F, 1'b1, 1'b0);
    probe(32'h2000_0100, "R8/R5");
    // R3: inclusive limit edge and just beyond / below base
    probe(32'h2000_01FF, "R3");
    probe(32'h2000_0200, "R3");
    probe(32'h2000_00FF, "R3");
    // R2: map aliases through the same region span
    writeRegion(5, 27'h000_0000, 27'h7FF_FFFF, 1'b1, 1'b0);
    probe(32'h0C00_0000, "R2");
    probe(32'h0BFF_FFFF, "R2");
    probe(32'h5000_0000, "R2");
    probe(32'hE000_0000, "R2");
    probe(32'h1000_0000, "R2");
    probe(32'h6000_0000, "R2");
    // R6: overlap of regions 2 and 5
    probe(32'h2000_0140, "R6");
    // R5: callable flag, region 7 index
    writeRegion(5, 27'h000_0000, 27'h000_0000, 1'b0, 1'b0);
    writeRegion(7, 27'h180_0000, 27'h180_0001, 1'b1, 1'b1);
    probe(32'h3000_0000, "R5");
    probe(32'h3000_0020, "R5");
    // R8: rewrite of region 7 leaves region 2 intact
    writeRegion(7, 27'h180_0000, 27'h180_0001, 1'b0, 1'b1);
    probe(32'h3000_0000, "R8");
    probe(32'h2000_0180, "R8");
    // R1 again with regions live
    secEnable = 1'b0;
    probe(32'h2000_0180, "R1");
    secEnable = 1'b1;

    // Random configurations and addresses near region bounds
    for (int it = 0; it < 60; it++) begin
      int idx = int'($urandom_range(0, NREG - 1));
      logic [3:0] nib = 4'($urandom_range(0, 15));
      logic [26:0] b = {nib, 23'($urandom_range(0, 63))};
      logic [26:0] l = b + 27'($urandom_range(0, 20));
      writeRegion(idx, b, l, ($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)));
      for (int k = 0; k < 12; k++) begin
        int j = int'($urandom_range(0, NREG - 1));
        logic [31:0] a = {mBase[j], 5'b0} + 32'($urandom_range(0, 800)) - 32'd64;
        if ($urandom_range(0, 9) == 0) secEnable = 1'b0;
        probeAuto(a);
        secEnable = 1'b1;
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule